// File: doc/BRIEF.md
# Serial Flash Two-Byte Command Sequencer

This block sits above a byte-wide SPI transfer engine and turns a single request into a complete framed flash transaction. A read request sends a read opcode, a run of dummy pad bytes and two more pad bytes whose returned values are the stored data. A write request sends a write opcode, a run of address/pad bytes and then the two data bytes to be stored. Chip select stays low from before the opcode until after the final byte. The block has no bit-level timing of its own. The engine does the shifting, and this block only loads one byte at a time, pulses start and waits for the engine to report completion.

The engine's completion output is a level that may stay high for several clocks. The sequencer passes it through a two-flop rising-edge detector, so each finished byte advances the sequence once and only once. After a read, the two captured bytes appear on output registers together with a one-cycle valid strobe. Requests that arrive during a transaction are dropped.

Top module: `flash_pair_seq`

## Requirements
- R1: A read transaction sends exactly 11 bytes: 0xD2 first, then ten 0x00 bytes.
- R2: A write transaction sends exactly 6 bytes in this order: 0x82, three 0x00 bytes, `wr_data0`, then `wr_data1`. The data values are the ones present on the cycle the request was accepted.
- R3: `cs_n` goes low on the cycle after an accepted request, before the first `xfer_start`. It stays low without a break until the last byte completes. No `xfer_start` is ever issued while `cs_n` is high.
- R4: `xfer_start` is high for exactly one cycle per byte. The next byte is started only after the engine has reported completion of the current one, so a start never overlaps a transfer in flight.
- R5: A completion level held high for any number of cycles, including until the next start, advances the sequence by exactly one byte.
- R6: After a read, `rd_data0` holds the byte returned during the 10th transfer and `rd_data1` holds the byte returned during the 11th. `rd_valid` pulses high for one cycle, on the same cycle `cs_n` returns high.
- R7: `busy` is high from the cycle after an accepted request until the cycle `cs_n` returns high, and it falls on that same cycle.
- R8: `rd_req` and `wr_req` are ignored while `busy` is high. When both are asserted together in idle, the read is taken.
- R9: A synchronous reset, asserted at any time, returns the block to idle with `cs_n` high and `xfer_start`, `busy` and `rd_valid` low.
- R10: A write transaction produces no `rd_valid` pulse and leaves `rd_data0`/`rd_data1` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_req | input | 1 | Start a two-byte read when idle |
| wr_req | input | 1 | Start a two-byte write when idle |
| wr_data0 | input | 8 | First byte to write, sampled at request |
| wr_data1 | input | 8 | Second byte to write, sampled at request |
| busy | output | 1 | Transaction in progress |
| rd_data0 | output | 8 | First byte read back |
| rd_data1 | output | 8 | Second byte read back |
| rd_valid | output | 1 | One-cycle strobe when read data is updated |
| cs_n | output | 1 | Flash chip select, active low |
| xfer_byte | output | 8 | Byte handed to the SPI engine |
| xfer_start | output | 1 | One-cycle start strobe to the engine |
| xfer_done | input | 1 | Engine completion level, may last many cycles |
| xfer_rx | input | 8 | Byte received by the engine, valid while done |

## Verification
The bench models an engine whose completion level lasts a random number of cycles, sometimes until the next start. A sequencer that reacted to the level would skip bytes and send too short a frame. Reads are checked against the exact values the model returned on transfers 10 and 11, so capturing one byte early or late shows up as wrong data. Requests that arrive mid-frame carry different data; accepting them would corrupt the frame or open a second one. A reset in the middle of a frame, a read and a write requested together, and writes that must leave the read registers untouched cover recovery, priority and isolation of the outputs.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LOAD   = 2'd1,
      ST_WAIT   = 2'd2,
      ST_FINISH = 2'd3
   } seq_state_t;

   typedef enum logic {
      OP_WRITE = 1'b0,
      OP_READ  = 1'b1
   } seq_op_t;

endpackage

// File: rtl/fps_edge_det.sv
// Rising-edge detector on a multi-cycle level: a chain of STAGES flops,
// pulse when the newest stage is high and the next-older stage is low.
module fps_edge_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic level,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fps_edge_det: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= '0;
      end else begin
         chain <= {chain[STAGES-2:0], level};
      end
   end

   assign rise = chain[STAGES-2] & ~chain[STAGES-1];
endmodule

// File: rtl/fps_byte_pick.sv
// Chooses the byte for transfer index idx of the current operation.
module fps_byte_pick
   import flash_seq_pkg::*;
#(
   parameter int          DATA_W    = 8,
   parameter int          IDX_W     = 4,
   parameter int          READ_PAD  = 8,
   parameter int          WRITE_PAD = 3,
   parameter logic [7:0]  READ_OP   = 8'hD2,
   parameter logic [7:0]  WRITE_OP  = 8'h82,
   parameter logic [7:0]  PAD_BYTE  = 8'h00
) (
   input  seq_op_t           op,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wd0,
   input  logic [DATA_W-1:0] wd1,
   output logic [DATA_W-1:0] byte_o
);
   localparam int WD0_IDX = WRITE_PAD + 1;

   logic [DATA_W-1:0] rd_pick;
   logic [DATA_W-1:0] wr_pick;

   always_comb begin
      if (idx == '0) rd_pick = DATA_W'(READ_OP);
      else           rd_pick = DATA_W'(PAD_BYTE);
   end

   always_comb begin
      if (idx == '0)                         wr_pick = DATA_W'(WRITE_OP);
      else if (int'(idx) <= WRITE_PAD)       wr_pick = DATA_W'(PAD_BYTE);
      else if (int'(idx) == WD0_IDX)         wr_pick = wd0;
      else                                   wr_pick = wd1;
   end

   assign byte_o = (op == OP_READ) ? rd_pick : wr_pick;
endmodule

// File: rtl/fps_fsm.sv
// Transaction control: framing, per-byte handshake and read capture.
module fps_fsm
   import flash_seq_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int IDX_W         = 4,
   parameter int READ_PAD      = 8,
   parameter int WRITE_PAD     = 3,
   parameter bit READ_PRIORITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_req,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data0,
   input  logic [DATA_W-1:0] wr_data1,
   input  logic              done_rise,
   input  logic [DATA_W-1:0] rx_byte,
   output seq_op_t           op,
   output logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] wd0_q,
   output logic [DATA_W-1:0] wd1_q,
   output logic              load,
   output logic              busy,
   output logic              cs_n,
   output logic              start,
   output logic [DATA_W-1:0] rd_data0,
   output logic [DATA_W-1:0] rd_data1,
   output logic              rd_valid
);
   localparam int RD_TOTAL = READ_PAD + 3;
   localparam int WR_TOTAL = WRITE_PAD + 3;
   localparam int RD_CAP0  = READ_PAD + 1;
   localparam int RD_CAP1  = READ_PAD + 2;

   seq_state_t        state;
   logic              take_rd;
   logic              take_wr;
   logic              last_byte;
   logic [DATA_W-1:0] cap0;
   logic [DATA_W-1:0] cap1;

   if (READ_PRIORITY) begin : g_rd_first
      assign take_rd = rd_req;
      assign take_wr = wr_req & ~rd_req;
   end else begin : g_wr_first
      assign take_wr = wr_req;
      assign take_rd = rd_req & ~wr_req;
   end

   always_comb begin
      if (op == OP_READ) last_byte = (int'(idx) == RD_TOTAL - 1);
      else               last_byte = (int'(idx) == WR_TOTAL - 1);
   end

   assign load = (state == ST_LOAD);
   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         op       <= OP_READ;
         idx      <= '0;
         wd0_q    <= '0;
         wd1_q    <= '0;
         cs_n     <= 1'b1;
         start    <= 1'b0;
         cap0     <= '0;
         cap1     <= '0;
         rd_data0 <= '0;
         rd_data1 <= '0;
         rd_valid <= 1'b0;
      end else begin
         start    <= 1'b0;
         rd_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (take_rd) begin
                  op    <= OP_READ;
                  idx   <= '0;
                  cs_n  <= 1'b0;
                  state <= ST_LOAD;
               end else if (take_wr) begin
                  op    <= OP_WRITE;
                  idx   <= '0;
                  wd0_q <= wr_data0;
                  wd1_q <= wr_data1;
                  cs_n  <= 1'b0;
                  state <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               start <= 1'b1;
               state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (done_rise) begin
                  if (op == OP_READ && int'(idx) == RD_CAP0) cap0 <= rx_byte;
                  if (op == OP_READ && int'(idx) == RD_CAP1) cap1 <= rx_byte;
                  if (last_byte) begin
                     state <= ST_FINISH;
                  end else begin
                     idx   <= idx + 1'b1;
                     state <= ST_LOAD;
                  end
               end
            end
            ST_FINISH: begin
               cs_n  <= 1'b1;
               state <= ST_IDLE;
               if (op == OP_READ) begin
                  rd_data0 <= cap0;
                  rd_data1 <= cap1;
                  rd_valid <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/flash_pair_seq.sv
module flash_pair_seq
   import flash_seq_pkg::*;
#(
   parameter int          DATA_W        = 8,
   parameter int          READ_PAD      = 8,
   parameter int          WRITE_PAD     = 3,
   parameter int          EDGE_STAGES   = 2,
   parameter bit          READ_PRIORITY = 1'b1,
   parameter logic [7:0]  READ_OP       = 8'hD2,
   parameter logic [7:0]  WRITE_OP      = 8'h82,
   parameter logic [7:0]  PAD_BYTE      = 8'h00
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_req,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data0,
   input  logic [DATA_W-1:0] wr_data1,
   output logic              busy,
   output logic [DATA_W-1:0] rd_data0,
   output logic [DATA_W-1:0] rd_data1,
   output logic              rd_valid,
   output logic              cs_n,
   output logic [DATA_W-1:0] xfer_byte,
   output logic              xfer_start,
   input  logic              xfer_done,
   input  logic [DATA_W-1:0] xfer_rx
);
   localparam int RD_TOTAL  = READ_PAD + 3;
   localparam int WR_TOTAL  = WRITE_PAD + 3;
   localparam int MAX_TOTAL = (RD_TOTAL > WR_TOTAL) ? RD_TOTAL : WR_TOTAL;
   localparam int IDX_W     = $clog2(MAX_TOTAL + 1);

   if (DATA_W < 8) begin : g_bad_width
      $error("flash_pair_seq: DATA_W must be at least 8");
   end
   if (READ_PAD < 0 || WRITE_PAD < 0) begin : g_bad_pad
      $error("flash_pair_seq: pad counts must not be negative");
   end

   seq_op_t           op;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] wd0_q;
   logic [DATA_W-1:0] wd1_q;
   logic [DATA_W-1:0] next_byte;
   logic              load;
   logic              done_rise;

   fps_edge_det #(
      .STAGES (EDGE_STAGES)
   ) u_edge (
      .clk   (clk),
      .rst   (rst),
      .level (xfer_done),
      .rise  (done_rise)
   );

   fps_byte_pick #(
      .DATA_W    (DATA_W),
      .IDX_W     (IDX_W),
      .READ_PAD  (READ_PAD),
      .WRITE_PAD (WRITE_PAD),
      .READ_OP   (READ_OP),
      .WRITE_OP  (WRITE_OP),
      .PAD_BYTE  (PAD_BYTE)
   ) u_pick (
      .op     (op),
      .idx    (idx),
      .wd0    (wd0_q),
      .wd1    (wd1_q),
      .byte_o (next_byte)
   );

   fps_fsm #(
      .DATA_W        (DATA_W),
      .IDX_W         (IDX_W),
      .READ_PAD      (READ_PAD),
      .WRITE_PAD     (WRITE_PAD),
      .READ_PRIORITY (READ_PRIORITY)
   ) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .rd_req    (rd_req),
      .wr_req    (wr_req),
      .wr_data0  (wr_data0),
      .wr_data1  (wr_data1),
      .done_rise (done_rise),
      .rx_byte   (xfer_rx),
      .op        (op),
      .idx       (idx),
      .wd0_q     (wd0_q),
      .wd1_q     (wd1_q),
      .load      (load),
      .busy      (busy),
      .cs_n      (cs_n),
      .start     (xfer_start),
      .rd_data0  (rd_data0),
      .rd_data1  (rd_data1),
      .rd_valid  (rd_valid)
   );

   always_ff @(posedge clk) begin
      if (rst)       xfer_byte <= '0;
      else if (load) xfer_byte <= next_byte;
   end
endmodule

// File: rtl/flash_pair_seq_chk.sv
module flash_pair_seq_chk #(
   parameter int READ_PAD  = 8,
   parameter int WRITE_PAD = 3
) (
   input logic clk,
   input logic rst,
   input logic cs_n,
   input logic xfer_start,
   input logic busy,
   input logic rd_valid
);
   localparam int RD_TOTAL = READ_PAD + 3;
   localparam int WR_TOTAL = WRITE_PAD + 3;

   int unsigned starts;

   always_ff @(posedge clk) begin
      if (rst || cs_n) starts <= 0;
      else if (xfer_start) starts <= starts + 1;
   end

   assert_start_framed_R3: assert property (@(posedge clk) disable iff (rst)
      xfer_start |-> !cs_n);

   assert_start_single_R4: assert property (@(posedge clk) disable iff (rst)
      xfer_start |=> !xfer_start);

   // R1 / R2: a frame closes only after a full read or write byte count
   assert_frame_length_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(cs_n) |-> (starts == RD_TOTAL || starts == WR_TOTAL));

   assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      rd_valid |=> !rd_valid);

   assert_valid_at_close_R6: assert property (@(posedge clk) disable iff (rst)
      rd_valid |-> $rose(cs_n));

   assert_busy_framed_R7: assert property (@(posedge clk) disable iff (rst)
      busy != cs_n);

   assert_reset_state_R9: assert property (@(posedge clk)
      $past(rst) |-> (cs_n && !xfer_start && !busy && !rd_valid));
endmodule

bind flash_pair_seq flash_pair_seq_chk #(
   .READ_PAD  (READ_PAD),
   .WRITE_PAD (WRITE_PAD)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cs_n       (cs_n),
   .xfer_start (xfer_start),
   .busy       (busy),
   .rd_valid   (rd_valid)
);

// File: tb/flash_pair_seq_test.sv
module flash_pair_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int READ_PAD   = 8;
   localparam int WRITE_PAD  = 3;
   localparam int RD_TOTAL   = READ_PAD + 3;
   localparam int WR_TOTAL   = WRITE_PAD + 3;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rd_req = 1'b0;
   logic       wr_req = 1'b0;
   logic [7:0] wr_data0 = '0;
   logic [7:0] wr_data1 = '0;
   logic       busy;
   logic [7:0] rd_data0;
   logic [7:0] rd_data1;
   logic       rd_valid;
   logic       cs_n;
   logic [7:0] xfer_byte;
   logic       xfer_start;
   logic       xfer_done;
   logic [7:0] xfer_rx;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // engine model state
   int         bit_max  = 4;
   int         hold_max = 3;
   int         eng_cnt;
   int         eng_hold;
   int         eng_idx;
   int         last_len;
   int         bad_start;
   int         overlap;
   int         valid_cnt;
   int         cs_falls;
   int         cs_rises;
   logic       prev_cs;
   logic [7:0] sent [0:15];
   logic [7:0] rxh  [0:15];

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_pair_seq #(
      .READ_PAD  (READ_PAD),
      .WRITE_PAD (WRITE_PAD)
   ) uut (
      .clk        (clk),
      .rst        (rst),
      .rd_req     (rd_req),
      .wr_req     (wr_req),
      .wr_data0   (wr_data0),
      .wr_data1   (wr_data1),
      .busy       (busy),
      .rd_data0   (rd_data0),
      .rd_data1   (rd_data1),
      .rd_valid   (rd_valid),
      .cs_n       (cs_n),
      .xfer_byte  (xfer_byte),
      .xfer_start (xfer_start),
      .xfer_done  (xfer_done),
      .xfer_rx    (xfer_rx)
   );

   // Engine model and monitors, active on the falling edge
   always @(negedge clk) begin : engine
      logic [7:0] r;
      if (rst) begin
         xfer_done <= 1'b0;
         xfer_rx   <= '0;
         eng_cnt   <= 0;
         eng_hold  <= 0;
         eng_idx   <= 0;
         prev_cs   <= 1'b1;
      end else begin
         prev_cs <= cs_n;
         if (rd_valid) valid_cnt <= valid_cnt + 1;
         if (!cs_n && prev_cs) cs_falls <= cs_falls + 1;
         if (cs_n && !prev_cs) begin
            cs_rises <= cs_rises + 1;
            last_len <= eng_idx;
            eng_idx  <= 0;
         end
         if (xfer_start) begin
            if (cs_n) bad_start <= bad_start + 1;
            if (eng_cnt != 0) overlap <= overlap + 1;
            if (eng_idx < 16) sent[eng_idx] <= xfer_byte;
            eng_idx   <= eng_idx + 1;
            xfer_done <= 1'b0;
            eng_hold  <= 0;
            eng_cnt   <= 1 + int'($urandom_range(bit_max - 1, 0));
         end else if (eng_cnt > 1) begin
            eng_cnt <= eng_cnt - 1;
         end else if (eng_cnt == 1) begin
            r = 8'($urandom);
            eng_cnt   <= 0;
            xfer_done <= 1'b1;
            xfer_rx   <= r;
            if (eng_idx >= 1 && eng_idx <= 16) rxh[eng_idx-1] <= r;
            eng_hold  <= 1 + int'($urandom_range(hold_max - 1, 0));
         end else if (eng_hold > 1) begin
            eng_hold <= eng_hold - 1;
         end else if (eng_hold == 1) begin
            eng_hold  <= 0;
            xfer_done <= 1'b0;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input bit rd, input int i,
                                          input logic [7:0] d0, input logic [7:0] d1);
      if (rd) return (i == 0) ? 8'hD2 : 8'h00;
      if (i == 0) return 8'h82;
      if (i <= WRITE_PAD) return 8'h00;
      if (i == WRITE_PAD + 1) return d0;
      return d1;
   endfunction

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   // rd/wr: request lines; intrude: cycles before a mid-frame request (0 = none)
   task automatic run_txn(input bit rd, input bit wr, input logic [7:0] d0,
                          input logic [7:0] d1, input int intrude);
      bit         is_rd;
      int         vc0, fall0, rise0, tot;
      logic [7:0] old0, old1;
      is_rd = rd;
      vc0   = valid_cnt;
      fall0 = cs_falls;
      rise0 = cs_rises;
      old0  = rd_data0;
      old1  = rd_data1;
      @(negedge clk);
      rd_req = rd; wr_req = wr; wr_data0 = d0; wr_data1 = d1;
      @(negedge clk);
      rd_req = 0; wr_req = 0; wr_data0 = ~d0; wr_data1 = ~d1;
      check(busy == 1'b1, "R7 busy after request", busy, 1);
      check(cs_n == 1'b0 && xfer_start == 1'b0, "R3 cs low before first start",
            {cs_n, xfer_start}, 0);
      if (intrude > 0) begin
         repeat (intrude) @(negedge clk);
         rd_req = 1; wr_req = 1; wr_data0 = d0 ^ 8'h5A; wr_data1 = d1 ^ 8'hA5;
         @(negedge clk);
         rd_req = 0; wr_req = 0;
      end
      wait_idle();
      check(cs_n == 1'b1, "R7 busy falls with cs high", cs_n, 1);
      repeat (4) @(negedge clk);
      check(busy == 1'b0, "R8 no frame from ignored request", busy, 0);
      tot = is_rd ? RD_TOTAL : WR_TOTAL;
      check(last_len == tot, is_rd ? "R1 R5 read length" : "R2 R5 write length",
            last_len, tot);
      for (int i = 0; i < tot && i < 16; i++) begin
         logic [7:0] e;
         e = exp_byte(is_rd, i, d0, d1);
         check(sent[i] == e, is_rd ? "R1 read byte" : "R2 write byte", sent[i], e);
      end
      check(cs_falls == fall0 + 1 && cs_rises == rise0 + 1,
            "R3 one unbroken chip-select frame", cs_rises - rise0, 1);
      check(bad_start == 0, "R3 start with cs high", bad_start, 0);
      check(overlap == 0, "R4 start during transfer", overlap, 0);
      if (is_rd) begin
         check(valid_cnt == vc0 + 1, "R6 one valid pulse", valid_cnt - vc0, 1);
         check(rd_data0 == rxh[READ_PAD+1], "R6 rd_data0", rd_data0, rxh[READ_PAD+1]);
         check(rd_data1 == rxh[READ_PAD+2], "R6 rd_data1", rd_data1, rxh[READ_PAD+2]);
      end else begin
         check(valid_cnt == vc0, "R10 no valid on write", valid_cnt - vc0, 0);
         check(rd_data0 == old0 && rd_data1 == old1, "R10 read data kept",
               {rd_data0, rd_data1}, {old0, old1});
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5EED_1234));
      bad_start = 0; overlap = 0; valid_cnt = 0; cs_falls = 0; cs_rises = 0;
      last_len = 0;
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      check(cs_n == 1 && xfer_start == 0 && busy == 0 && rd_valid == 0,
            "R9 reset state", {cs_n, xfer_start, busy, rd_valid}, 4'b1000);

      // directed: short done pulse, plain read and write
      bit_max = 2; hold_max = 1;
      run_txn(1, 0, 8'h00, 8'h00, 0);
      run_txn(0, 1, 8'h3C, 8'hC3, 0);
      // directed: done held long, up to the next start (R5)
      bit_max = 6; hold_max = 12;
      run_txn(1, 0, 8'h00, 8'h00, 0);
      run_txn(0, 1, 8'hFF, 8'h01, 0);
      // directed: both requests at once, read taken (R8)
      run_txn(1, 1, 8'h77, 8'h88, 0);
      // directed: request arriving mid-frame is dropped (R8)
      run_txn(0, 1, 8'h12, 8'h34, 10);
      run_txn(1, 0, 8'h00, 8'h00, 25);

      // directed: reset in the middle of a read (R9)
      @(negedge clk);
      rd_req = 1;
      @(negedge clk);
      rd_req = 0;
      repeat (30) @(negedge clk);
      rst = 1;
      @(negedge clk);
      @(negedge clk);
      check(cs_n == 1 && xfer_start == 0 && busy == 0 && rd_valid == 0,
            "R9 reset mid-frame", {cs_n, xfer_start, busy, rd_valid}, 4'b1000);
      rst = 0;
      repeat (2) @(negedge clk);
      check(busy == 0 && cs_n == 1, "R9 idle after reset", {busy, cs_n}, 2'b01);
      run_txn(1, 0, 8'h00, 8'h00, 0);

      // random mix
      for (int t = 0; t < 40; t++) begin
         bit rd, wr;
         int intr;
         rd = 1'($urandom);
         wr = ~rd | 1'($urandom_range(3, 0) == 0);
         bit_max  = 1 + int'($urandom_range(7, 0));
         hold_max = 1 + int'($urandom_range(9, 0));
         intr = ($urandom_range(3, 0) == 0) ? 1 + int'($urandom_range(30, 0)) : 0;
         run_txn(rd, wr, 8'($urandom), 8'($urandom), intr);
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule